// File: doc/BRIEF.md
# Command Queue Consumer and Decoder

This block sits at the head of a command ring queue for an address-translation unit. Each cycle a fetch stage presents one 128-bit command, made of four 32-bit words, with word 0 in the low bits. The block decodes the 8-bit opcode and checks it against the set of legal commands. It pulls the argument fields out of the command and hands legal commands to the downstream invalidation and sync handlers through a one-entry valid/ready register. It pulses a consume strobe for every command it takes, so the fetch stage can advance its read index.

When a command is illegal, or the fetch of it aborted, the block does not consume that entry. It records a typed error code and toggles a global error bit, then stops. Processing restarts only after two things have happened. Software must write the error code back to zero, and the global error acknowledge input must be toggled to match the error bit.

Top module: `cmdq_consumer`

## Requirements
- R1: During and right after reset, `cmd_pop_o` and `disp_valid_o` are 0, `err_code_o` is 0 and `gerr_o` is 0.
- R2: No command is taken and no error is recorded unless both `glb_en_i` and `cq_en_i` are 1.
- R3: Legal opcodes are 0x01–0x07, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41 and 0x44–0x46. When the block is enabled, not halted and the dispatch slot is free or draining, a legal command with `cmd_valid_i` high raises `cmd_pop_o` in the same cycle. `disp_valid_o` is then 1 in the next cycle.
- R4: Dispatched fields are taken from the words of the command:
  - opcode: word0[7:0]
  - sync completion mode: word0[13:12]
  - stream ID: all of word1
  - VMID: word1[15:0]
  - ASID: word1[31:16]
  - range: word2[4:0]
  - leaf: word2[0]
  - TTL: word2[9:8]
  - granule: word2[11:10]
  - address: {word3, word2[31:12], 12'h000}
- R5: While `disp_valid_o` is 1 and `disp_ready_i` is 0, the dispatch outputs hold their values and no new command is popped.
- R6: An illegal opcode, including 0x00 and any value not in the R3 list, is not popped. In the next cycle `err_code_o` becomes 1 (illegal command) and `gerr_o` inverts.
- R7: A command presented with `fetch_err_i` high is not popped, whatever its opcode. In the next cycle `err_code_o` becomes 2 (fetch abort) and `gerr_o` inverts. Code 3 is reserved for a sync error, and 0 means no error.
- R8: The block is halted while `err_code_o` is not 0 or `gerr_o` differs from `gerr_ack_i`. While halted it pops nothing and the error code holds. `err_clr_i` sets the code to 0, and processing resumes once both halt conditions are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global unit enable |
| cq_en_i | input | 1 | Command queue enable |
| cmd_valid_i | input | 1 | A fetched command is present |
| cmd_i | input | 128 | Command, word0 in bits [31:0] |
| fetch_err_i | input | 1 | Fetch of the presented command aborted |
| cmd_pop_o | output | 1 | Consume strobe, advance the read index |
| disp_valid_o | output | 1 | Dispatch register holds a command |
| disp_ready_i | input | 1 | Handler takes the dispatched command |
| disp_op_o | output | 8 | Opcode |
| disp_sid_o | output | 32 | Stream ID |
| disp_vmid_o | output | 16 | VMID |
| disp_asid_o | output | 16 | ASID |
| disp_addr_o | output | 64 | Address |
| disp_range_o | output | 5 | Stream table range |
| disp_leaf_o | output | 1 | Leaf-only flag |
| disp_ttl_o | output | 2 | Table level hint |
| disp_tg_o | output | 2 | Granule |
| disp_sync_cs_o | output | 2 | Sync completion mode: 0 none, 1 interrupt, 2 send-event |
| err_code_o | output | 7 | Error code held in the consumer register |
| err_clr_i | input | 1 | Software writes the error code to zero |
| gerr_o | output | 1 | Global command queue error toggle bit |
| gerr_ack_i | input | 1 | Global error acknowledge toggle bit |

## Verification
`cmd_pop_o` is combinational, so it is due in the same cycle as the inputs that cause it. The dispatch register, `err_code_o` and `gerr_o` all change one clock after the accept or fault that causes them. The bench drives its inputs 1 ns after each rising edge. A behavioural model updates its state on the rising edge, and on the falling edge the bench compares every output against the model. A registered result is therefore compared half a cycle after the edge that should have produced it, and the pop strobe is compared against inputs that have been stable since the start of the cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CMD_W  = 4 * WORD_W;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned ERR_W  = 7;
  localparam int unsigned ADDR_W = 2 * WORD_W;

  localparam logic [ERR_W-1:0] ERR_NONE = ERR_W'(0);
  localparam logic [ERR_W-1:0] ERR_ILL  = ERR_W'(1);
  localparam logic [ERR_W-1:0] ERR_ABT  = ERR_W'(2);

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [WORD_W-1:0] sid;
    logic [ADDR_W-1:0] addr;
    logic [4:0]        range;
    logic              leaf;
    logic [1:0]        ttl;
    logic [1:0]        tg;
    logic [1:0]        sync_cs;
  } cq_cmd_t;

  function automatic logic op_legal(input logic [OP_W-1:0] op);
    return op inside {[8'h01:8'h07], [8'h10:8'h13], 8'h18, 8'h1a,
                      [8'h20:8'h23], 8'h28, 8'h2a, 8'h30, 8'h40, 8'h41,
                      [8'h44:8'h46]};
  endfunction
endpackage

// File: rtl/cq_decode.sv
module cq_decode
  import cq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cq_cmd_t          fields_o,
  output logic             legal_o
);
  logic [WORD_W-1:0] w0, w1, w2, w3;
  logic              unused_bits;

  assign w0 = cmd_i[0*WORD_W +: WORD_W];
  assign w1 = cmd_i[1*WORD_W +: WORD_W];
  assign w2 = cmd_i[2*WORD_W +: WORD_W];
  assign w3 = cmd_i[3*WORD_W +: WORD_W];

  assign fields_o.op      = w0[OP_W-1:0];
  assign fields_o.sync_cs = w0[13:12];
  assign fields_o.sid     = w1;
  assign fields_o.range   = w2[4:0];
  assign fields_o.leaf    = w2[0];
  assign fields_o.ttl     = w2[9:8];
  assign fields_o.tg      = w2[11:10];
  assign fields_o.addr    = {w3, w2[31:12], 12'h000};

  assign legal_o = op_legal(w0[OP_W-1:0]);

  assign unused_bits = ^{w0[31:14], w0[11:8], w2[7:5]};
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             cq_en_i,
  input  logic             cmd_valid_i,
  input  logic             fetch_err_i,
  input  logic             legal_i,
  input  logic             slot_free_i,
  input  logic             err_clr_i,
  input  logic             gerr_ack_i,
  output logic             accept_o,
  output logic [ERR_W-1:0] err_code_o,
  output logic             gerr_o
);
  logic [ERR_W-1:0] err_q;
  logic             gerr_q;
  logic             halted, try_cmd, fault;

  assign halted   = (err_q != ERR_NONE) || (gerr_q != gerr_ack_i);
  assign try_cmd  = glb_en_i && cq_en_i && !halted && cmd_valid_i && slot_free_i;
  assign fault    = try_cmd && (fetch_err_i || !legal_i);
  assign accept_o = try_cmd && !fetch_err_i && legal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= ERR_NONE;
      gerr_q <= 1'b0;
    end else if (fault) begin
      err_q  <= fetch_err_i ? ERR_ABT : ERR_ILL;
      gerr_q <= ~gerr_q;
    end else if (err_clr_i) begin
      err_q  <= ERR_NONE;
    end
  end

  assign err_code_o = err_q;
  assign gerr_o     = gerr_q;

  // R8
  pop_when_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != ERR_NONE || gerr_o != gerr_ack_i) |-> !accept_o);
  // R2
  pop_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glb_en_i && cq_en_i) |-> !accept_o);
  // R6
  err_rise_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != ERR_NONE && $past(err_code_o) == ERR_NONE) |-> !$past(accept_o));
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != ERR_NONE && !err_clr_i) |=> $stable(err_code_o));
endmodule

// File: rtl/cq_disp_reg.sv
module cq_disp_reg
  import cq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  cq_cmd_t fields_i,
  input  logic    ready_i,
  output logic    valid_o,
  output cq_cmd_t fields_o,
  output logic    free_o
);
  logic    valid_q;
  cq_cmd_t data_q;

  assign free_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= fields_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign fields_o = data_q;

  // R5
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(fields_o)));
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic               cq_en_i,
  input  logic               cmd_valid_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               fetch_err_i,
  output logic               cmd_pop_o,
  output logic               disp_valid_o,
  input  logic               disp_ready_i,
  output logic [OP_W-1:0]    disp_op_o,
  output logic [WORD_W-1:0]  disp_sid_o,
  output logic [15:0]        disp_vmid_o,
  output logic [15:0]        disp_asid_o,
  output logic [ADDR_W-1:0]  disp_addr_o,
  output logic [4:0]         disp_range_o,
  output logic               disp_leaf_o,
  output logic [1:0]         disp_ttl_o,
  output logic [1:0]         disp_tg_o,
  output logic [1:0]         disp_sync_cs_o,
  output logic [ERR_W-1:0]   err_code_o,
  input  logic               err_clr_i,
  output logic               gerr_o,
  input  logic               gerr_ack_i
);
  cq_cmd_t dec_fields, out_fields;
  logic    legal, slot_free, accept;

  cq_decode u_decode (
    .cmd_i    (cmd_i),
    .fields_o (dec_fields),
    .legal_o  (legal)
  );

  cq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .glb_en_i    (glb_en_i),
    .cq_en_i     (cq_en_i),
    .cmd_valid_i (cmd_valid_i),
    .fetch_err_i (fetch_err_i),
    .legal_i     (legal),
    .slot_free_i (slot_free),
    .err_clr_i   (err_clr_i),
    .gerr_ack_i  (gerr_ack_i),
    .accept_o    (accept),
    .err_code_o  (err_code_o),
    .gerr_o      (gerr_o)
  );

  cq_disp_reg u_disp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .fields_i (dec_fields),
    .ready_i  (disp_ready_i),
    .valid_o  (disp_valid_o),
    .fields_o (out_fields),
    .free_o   (slot_free)
  );

  assign cmd_pop_o      = accept;
  assign disp_op_o      = out_fields.op;
  assign disp_sid_o     = out_fields.sid;
  assign disp_vmid_o    = out_fields.sid[15:0];
  assign disp_asid_o    = out_fields.sid[31:16];
  assign disp_addr_o    = out_fields.addr;
  assign disp_range_o   = out_fields.range;
  assign disp_leaf_o    = out_fields.leaf;
  assign disp_ttl_o     = out_fields.ttl;
  assign disp_tg_o      = out_fields.tg;
  assign disp_sync_cs_o = out_fields.sync_cs;

  // R3
  pop_then_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pop_o |=> disp_valid_o);
endmodule

// File: tb/tb_cmdq_consumer.sv
`timescale 1ns/1ps
module tb_cmdq_consumer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         glb_en = 0, cq_en = 0, cmd_valid = 0, fetch_err = 0;
  logic [127:0] cmd = '0;
  logic         disp_ready = 1, err_clr = 0, gerr_ack = 0;
  logic         pop, dv, leaf, gerr;
  logic [7:0]   op;
  logic [31:0]  sid;
  logic [15:0]  vmid, asid;
  logic [63:0]  addr;
  logic [4:0]   rng;
  logic [1:0]   ttl, tg, cs;
  logic [6:0]   err;

  always #2.5 clk = ~clk;

  cmdq_consumer dut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .cq_en_i(cq_en),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .fetch_err_i(fetch_err),
    .cmd_pop_o(pop), .disp_valid_o(dv), .disp_ready_i(disp_ready),
    .disp_op_o(op), .disp_sid_o(sid), .disp_vmid_o(vmid), .disp_asid_o(asid),
    .disp_addr_o(addr), .disp_range_o(rng), .disp_leaf_o(leaf),
    .disp_ttl_o(ttl), .disp_tg_o(tg), .disp_sync_cs_o(cs),
    .err_code_o(err), .err_clr_i(err_clr), .gerr_o(gerr), .gerr_ack_i(gerr_ack)
  );

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit    started = 0;
  byte unsigned legal_q[$] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
    8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1a, 8'h20, 8'h21, 8'h22, 8'h23,
    8'h28, 8'h2a, 8'h30, 8'h40, 8'h41, 8'h44, 8'h45, 8'h46};

  function automatic bit is_legal(input byte unsigned o);
    foreach (legal_q[k]) if (legal_q[k] == o) return 1;
    return 0;
  endfunction

  // behavioural reference
  bit           m_dv, m_gerr;
  int           m_err;
  logic [127:0] m_cmd;

  function automatic bit m_go();
    bit halt = (m_err != 0) || (m_gerr != gerr_ack);
    return glb_en && cq_en && !halt && cmd_valid && (!m_dv || disp_ready);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dv <= 0; m_gerr <= 0; m_err <= 0; m_cmd <= '0;
    end else begin
      if (m_go() && (fetch_err || !is_legal(cmd[7:0]))) begin
        m_err  <= fetch_err ? 2 : 1;
        m_gerr <= !m_gerr;
      end else begin
        if (err_clr) m_err <= 0;
        if (m_go()) begin
          m_dv <= 1; m_cmd <= cmd;
        end else if (disp_ready) m_dv <= 0;
      end
    end
  end

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(phase, "pop", 64'(pop), 64'(m_go() && !fetch_err && is_legal(cmd[7:0])));
    chk("R5", "disp_valid", 64'(dv), 64'(m_dv));
    chk(phase, "err_code", 64'(err), 64'(m_err));
    chk(phase, "gerr", 64'(gerr), 64'(m_gerr));
    if (m_dv) begin
      // R4 field positions
      chk("R4", "op", 64'(op), 64'(m_cmd[7:0]));
      chk("R4", "sync_cs", 64'(cs), 64'(m_cmd[13:12]));
      chk("R4", "sid", 64'(sid), 64'(m_cmd[63:32]));
      chk("R4", "vmid", 64'(vmid), 64'(m_cmd[47:32]));
      chk("R4", "asid", 64'(asid), 64'(m_cmd[63:48]));
      chk("R4", "addr", addr, {m_cmd[127:96], m_cmd[95:76], 12'h000});
      chk("R4", "range", 64'(rng), 64'(m_cmd[68:64]));
      chk("R4", "leaf", 64'(leaf), 64'(m_cmd[64]));
      chk("R4", "ttl", 64'(ttl), 64'(m_cmd[73:72]));
      chk("R4", "tg", 64'(tg), 64'(m_cmd[75:74]));
    end
  end

  function automatic logic [127:0] mk(input byte unsigned o, input int i);
    logic [127:0] c;
    c = {32'hC0DE0000 + i * 32'h00111111, 32'h87654321 + i * 32'h01010101,
         32'h12345000 ^ (i * 32'h3F), 32'hABCD0000 ^ (i << 12)};
    c[7:0] = o;
    return c;
  endfunction

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic fault_and_recover(input string r, input byte unsigned o, input bit fe, input int i);
    phase = r; cmd = mk(o, i); fetch_err = fe; cmd_valid = 1; cyc();
    fetch_err = 0; cmd = mk(8'h03, i + 1); cyc(2);   // halted, R8
    phase = "R8"; err_clr = 1; cyc(); err_clr = 0; cyc(2); // ack still pending
    gerr_ack = m_gerr; cyc(2);                       // resumes
    cmd_valid = 0; cyc();
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        @(posedge clk); started = 1;
        phase = "R1"; cyc(3); rst_n = 1; cyc(1);
        phase = "R2"; cmd_valid = 1; cmd = mk(8'h03, 0);
        glb_en = 0; cq_en = 1; cyc(2);
        glb_en = 1; cq_en = 0; cyc(2);
        cq_en = 1;
        phase = "R3";
        for (int i = 0; i < legal_q.size(); i++) begin
          cmd = mk(legal_q[i], i); cmd[13:12] = 2'(i % 3); cyc();
        end
        phase = "R5"; disp_ready = 0; cmd = mk(8'h46, 40); cyc(3);
        disp_ready = 1; cyc(); cmd = mk(8'h2a, 41); disp_ready = 0; cyc(2);
        disp_ready = 1; cmd_valid = 0; cyc(2);
        fault_and_recover("R6", 8'h00, 0, 50);
        fault_and_recover("R6", 8'h47, 0, 60);
        fault_and_recover("R6", 8'h1b, 0, 70);
        fault_and_recover("R6", 8'h08, 0, 80);
        fault_and_recover("R7", 8'h10, 1, 90);
        fault_and_recover("R7", 8'hff, 1, 100);
        phase = "R3"; cmd_valid = 1; cmd = mk(8'h01, 110); cyc(2);
        cmd_valid = 0; cyc(2);
      end
      begin
        while (wd < 20000) begin @(posedge clk); wd++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", wd);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule